// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with LRU Replacement

This block is a small read/write cache between a requester and a slower word memory. Every set holds two lines of four words each. On a lookup both ways compare their stored tags with the request at the same time. At most one valid way can match, and that way's addressed word is steered out. A read miss stalls the requester while the whole line is fetched from memory into a victim way. After the refill the lookup is replayed and now hits. Writes always go through to memory. They update the cached copy only when the line is already present, so a write miss allocates nothing.

The requester side uses a valid/ready stream. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the response has been consumed, so there is at most one access in flight. The response is offered on `rsp_valid`. It is held with stable data until `rsp_ready` is seen high at a clock edge. The memory read request and the memory write port are valid/ready as well, and both keep their address and data steady while they stall. Refill beats arrive on `mem_fill_valid` with no back-pressure, because the cache always accepts them.

Top module: `assoc2_cache`

## Requirements
- R1: Each set holds two lines, so two addresses with the same set index and different tags can both be resident and both hit. At most one way ever matches a lookup.
- R2: The address splits as follows: bits [3:2] select the word within a line, bits [6:4] select one of 8 sets, and bits [31:7] form the 25-bit tag. Bits [1:0] do not affect which word is returned.
- R3: A read hit returns the stored word with `rsp_hit`=1 and issues no memory read.
- R4: A read miss issues exactly one memory read whose address has bits [3:0] zero. It then accepts four fill beats for words 0,1,2,3 in that order and returns the requested word with `rsp_hit`=0. Memory reads and memory writes are never requested in the same cycle.
- R5: The victim on a miss is the first invalid way (way 0 before way 1). When both ways are valid, the victim is the least recently used way.
- R6: The recency state of a set is updated on every hit (read or write) and on every completed fill. The way touched becomes most recently used.
- R7: Every write produces exactly one memory write carrying the request address and data, held stable while `mem_wr_ready` is low. A write hit updates the cached word, and a write miss leaves the cache contents unchanged.
- R8: `req_ready` is high only when no access is in progress. A pending response keeps `rsp_valid`, `rsp_rdata` and `rsp_hit` stable until `rsp_ready` is high at a clock edge.
- R9: Reset invalidates every line and clears recency. After reset `req_ready`=1 and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data (meaningful for reads) |
| rsp_hit | output | 1 | 1 when the access hit on its first lookup |
| mem_rd_valid | output | 1 | Line read request to memory |
| mem_rd_ready | input | 1 | Memory accepts the line read |
| mem_rd_addr | output | 32 | Line-aligned read address |
| mem_fill_valid | input | 1 | Refill beat present |
| mem_fill_data | input | 32 | Refill word |
| mem_wr_valid | output | 1 | Write-through request to memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |

## Verification
The hardest state to reach from the ports is an eviction decided purely by recency. Both ways of one set must be valid, and the way that was filled first must have been touched more recently than the other. The stimulus table gets there with a chain of addresses sharing set 0 but carrying three different tags. It interleaves misses and hits so that the expected victim alternates between the ways. Each eviction is then exposed by a later read that misses where it would otherwise hit. A write miss followed by a read of the same word shows that no allocation happened and that the memory copy changed.

// File: rtl/assoc2_cache_pkg.sv
package assoc2_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FETCH,
    ST_FILL,
    ST_WRITE,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/assoc2_cache_way.sv
module assoc2_cache_way #(
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 25,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic [WSEL_W-1:0] wsel,
  input  logic              fill_we,
  input  logic [WSEL_W-1:0] fill_wsel,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_last,
  input  logic              hit_we,
  input  logic [DATA_W-1:0] hit_wdata,
  output logic              hit,
  output logic              valid,
  output logic [DATA_W-1:0] rdata
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS][WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_we && fill_last) begin
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we && fill_last) begin
      tag_q[idx] <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      data_q[idx][fill_wsel] <= fill_data;
    end else if (hit_we) begin
      data_q[idx][wsel] <= hit_wdata;
    end
  end

  assign valid = valid_q[idx];
  assign hit   = valid_q[idx] && (tag_q[idx] == tag);
  assign rdata = data_q[idx][wsel];
endmodule

// File: rtl/assoc2_cache_lru.sv
module assoc2_cache_lru #(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             valid0,
  input  logic             valid1,
  input  logic             touch,
  input  logic             touch_way,
  output logic             victim
);
  // One bit per set naming the way not used most recently.
  logic [SETS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (touch) begin
      older_q[idx] <= ~touch_way;
    end
  end

  always_comb begin
    if (!valid0)      victim = 1'b0;
    else if (!valid1) victim = 1'b1;
    else              victim = older_q[idx];
  end
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
  import assoc2_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int BYTE_W   = $clog2(DATA_W / 8);
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int IDX_W    = $clog2(SETS);
  localparam int LINE_OFF = BYTE_W + WSEL_W;
  localparam int TAG_W    = ADDR_W - IDX_W - LINE_OFF;
  localparam int NWAYS    = 2;

  cache_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              missed_q;
  logic              victim_q;
  logic [WSEL_W-1:0] beat_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [NWAYS-1:0]  way_hit;
  logic [NWAYS-1:0]  way_valid;
  logic [DATA_W-1:0] way_rdata [NWAYS];
  logic              any_hit;
  logic              hit_way;
  logic              victim;
  logic              fill_last;
  logic              lru_touch;
  logic              lru_way;

  assign idx  = addr_q[LINE_OFF +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[BYTE_W +: WSEL_W];

  assign any_hit   = |way_hit;
  assign hit_way   = way_hit[1];
  assign fill_last = (state_q == ST_FILL) && mem_fill_valid &&
                     (beat_q == WSEL_W'(WORDS - 1));

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic way_fill_we;
    logic way_hit_we;
    assign way_fill_we = (state_q == ST_FILL) && mem_fill_valid && (victim_q == w[0]);
    assign way_hit_we  = (state_q == ST_LOOKUP) && we_q && way_hit[w];

    assoc2_cache_way #(
      .SETS  (SETS),
      .WORDS (WORDS),
      .DATA_W(DATA_W),
      .TAG_W (TAG_W)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (idx),
      .tag      (tag),
      .wsel     (wsel),
      .fill_we  (way_fill_we),
      .fill_wsel(beat_q),
      .fill_data(mem_fill_data),
      .fill_last(fill_last),
      .hit_we   (way_hit_we),
      .hit_wdata(wdata_q),
      .hit      (way_hit[w]),
      .valid    (way_valid[w]),
      .rdata    (way_rdata[w])
    );
  end

  assign lru_touch = ((state_q == ST_LOOKUP) && any_hit) || fill_last;
  assign lru_way   = (state_q == ST_FILL) ? victim_q : hit_way;

  assoc2_cache_lru #(
    .SETS(SETS)
  ) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx),
    .valid0   (way_valid[0]),
    .valid1   (way_valid[1]),
    .touch    (lru_touch),
    .touch_way(lru_way),
    .victim   (victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      missed_q <= 1'b0;
      victim_q <= 1'b0;
      beat_q   <= '0;
      rdata_q  <= '0;
      hit_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q   <= req_addr;
            we_q     <= req_we;
            wdata_q  <= req_wdata;
            missed_q <= 1'b0;
            state_q  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (we_q) begin
            hit_q   <= any_hit;
            state_q <= ST_WRITE;
          end else if (any_hit) begin
            rdata_q <= way_rdata[hit_way];
            hit_q   <= !missed_q;
            state_q <= ST_RESP;
          end else begin
            victim_q <= victim;
            missed_q <= 1'b1;
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rd_ready) begin
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_fill_valid) begin
            beat_q <= beat_q + 1'b1;
            if (fill_last) state_q <= ST_LOOKUP;
          end
        end
        ST_WRITE: begin
          if (mem_wr_ready) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_hit      = hit_q;
  assign mem_rd_valid = (state_q == ST_FETCH);
  assign mem_rd_addr  = {addr_q[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
  assign mem_wr_valid = (state_q == ST_WRITE);
  assign mem_wr_addr  = addr_q;
  assign mem_wr_data  = wdata_q;
endmodule

// File: rtl/assoc2_cache_chk.sv
module assoc2_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int LINE_OFF = $clog2(DATA_W / 8) + $clog2(WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_hit,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic [1:0]        way_hit
);
  assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  assert_rd_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[LINE_OFF-1:0] == '0));

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_no_rd_wr_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && mem_wr_valid));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit)));

  assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid || mem_wr_valid) |-> !req_ready);
endmodule

bind assoc2_cache assoc2_cache_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WORDS (WORDS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_hit     (rsp_hit),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .way_hit     (way_hit)
);

// File: tb/assoc2_cache_bench.sv
module assoc2_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_hit;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_fill_valid = 1'b0;
  logic [31:0] mem_fill_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int wr_count = 0;
  int bad_align = 0;
  logic [31:0] bmem    [1024];
  logic [31:0] shadow  [1024];

  always #10 clk = ~clk;

  assoc2_cache u_assoc2_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: one line read takes a handshake then four beats, words 0..3.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [31:0] base;
        base = mem_rd_addr;
        if (base[3:0] != 4'h0) bad_align++;
        rd_count++;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        for (int b = 0; b < 4; b++) begin
          mem_fill_valid = 1'b1;
          mem_fill_data  = bmem[base[11:2] + 10'(b)];
          @(negedge clk);
        end
        mem_fill_valid = 1'b0;
      end else if (mem_wr_valid) begin
        @(negedge clk);
        mem_wr_ready = 1'b1;
        @(posedge clk);
        bmem[mem_wr_addr[11:2]] = mem_wr_data;
        wr_count++;
        @(negedge clk);
        mem_wr_ready = 1'b0;
      end
    end
  end

  // Vector: {we, addr, wdata, expected hit}
  localparam int NV = 19;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 32'h000, 32'h0,        1'b0}, // R4 cold miss set 0, fills way 0 (R5)
    {1'b0, 32'h005, 32'h0,        1'b1}, // R2 R3 word 1, byte bits ignored
    {1'b0, 32'h080, 32'h0,        1'b0}, // R5 same set new tag, fills invalid way 1
    {1'b0, 32'h008, 32'h0,        1'b1}, // R1 both resident; R6 0x000 now recent
    {1'b0, 32'h100, 32'h0,        1'b0}, // R5 evicts 0x080 line
    {1'b0, 32'h00C, 32'h0,        1'b1}, // R5 0x000 line survived
    {1'b0, 32'h080, 32'h0,        1'b0}, // R6 0x100 line older, evicted
    {1'b0, 32'h104, 32'h0,        1'b0}, // R6 evicts 0x000 line
    {1'b0, 32'h084, 32'h0,        1'b1}, // R1 0x080 line still present
    {1'b1, 32'h004, 32'h11112222, 1'b0}, // R7 write miss, no allocate
    {1'b0, 32'h004, 32'h0,        1'b0}, // R7 misses, sees written memory; evicts 0x100
    {1'b1, 32'h008, 32'h33334444, 1'b1}, // R7 write hit updates cache
    {1'b0, 32'h008, 32'h0,        1'b1}, // R7 cached word updated
    {1'b0, 32'h01C, 32'h0,        1'b0}, // R2 set 1 word 3
    {1'b0, 32'h010, 32'h0,        1'b1}, // R2 set 1 word 0
    {1'b0, 32'h108, 32'h0,        1'b0}, // R6 write hit made 0x000 recent, evicts 0x080
    {1'b0, 32'h088, 32'h0,        1'b0}, // R6 evicts 0x000 line
    {1'b0, 32'h07C, 32'h0,        1'b0}, // R2 set 7
    {1'b0, 32'h070, 32'h0,        1'b1}  // R3 set 7 hit
  };

  task automatic send(input logic we, input logic [31:0] addr, input logic [31:0] wdata);
    req_we    = we;
    req_addr  = addr;
    req_wdata = wdata;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bmem[i]   = (32'(i) << 16) ^ 32'(i) ^ 32'hC0DE0000;
      shadow[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 req_ready after reset", {31'b0, req_ready}, 32'd1);
    check("R9 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check("R9 mem_rd_valid after reset", {31'b0, mem_rd_valid}, 32'd0);
    check("R9 mem_wr_valid after reset", {31'b0, mem_wr_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic        we;
      logic [31:0] addr, wdata;
      logic        exp_hit;
      int          rd0, wr0;
      {we, addr, wdata, exp_hit} = VEC[v];
      rd0 = rd_count;
      wr0 = wr_count;
      send(we, addr, wdata);
      check($sformatf("R3/R4/R5 hit flag vec %0d", v), {31'b0, rsp_hit}, {31'b0, exp_hit});
      if (we) begin
        shadow[addr[11:2]] = wdata;
        check($sformatf("R7 mem writes vec %0d", v), 32'(wr_count - wr0), 32'd1);
        check($sformatf("R7 mem content vec %0d", v), bmem[addr[11:2]], wdata);
      end else begin
        check($sformatf("R3/R4 read data vec %0d", v), rsp_rdata, shadow[addr[11:2]]);
        check($sformatf("R3/R4 mem reads vec %0d", v), 32'(rd_count - rd0),
              exp_hit ? 32'd0 : 32'd1);
      end
      @(negedge clk);
    end
    check("R4 line aligned reads", 32'(bad_align), 32'd0);

    // R8: response held under back-pressure
    begin
      logic [31:0] held;
      rsp_ready = 1'b0;
      send(1'b0, 32'h074, 32'h0);
      held = rsp_rdata;
      check("R8 read data under stall", held, shadow[10'h1D]);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R8 rsp_valid held", {31'b0, rsp_valid}, 32'd1);
        check("R8 rsp_rdata stable", rsp_rdata, held);
        check("R8 req_ready low while busy", {31'b0, req_ready}, 32'd0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      check("R8 rsp_valid drops after take", {31'b0, rsp_valid}, 32'd0);
      check("R8 req_ready back", {31'b0, req_ready}, 32'd1);
    end

    // R9: reset invalidates lines that were resident
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 req_ready after second reset", {31'b0, req_ready}, 32'd1);
    begin
      int rd0;
      rd0 = rd_count;
      send(1'b0, 32'h070, 32'h0);
      check("R9 formerly cached line misses", {31'b0, rsp_hit}, 32'd0);
      check("R9 refetch count", 32'(rd_count - rd0), 32'd1);
      check("R9 refetched data", rsp_rdata, shadow[10'h1C]);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule